// File: doc/BRIEF.md
# Programmable Strobe Rail Sequencer

This block brings up a group of supply rails in an order that software can choose. A power-enable request starts a walk through ten numbered strobe slots. Each gap between two slots lasts either two or five milliseconds, and each gap is chosen on its own. Every rail is bound to one slot, and several rails can share a slot. When a slot fires, the enable of every rail bound to it goes high and stays high. When the request drops, all enables clear together and the block goes back to idle.

The slot bindings and gap choices sit in a small register bank. The bank is written through a plain address/data/strobe port that stands in for a serial management slave. After reset the bank holds a usable default order, so the block runs with no configuration. The millisecond base comes from a prescaler set by a clock-cycles-per-millisecond parameter.

Top module: `rail_sequencer`

## Requirements
- R1: After reset, all enables, `seq_busy` and `seq_done` are low. Rail i is bound to slot (i mod 10)+1. Every gap is set to 2 ms.
- R2: The first clock edge that samples `pwr_en` high after it was low starts the sequence. At that same edge, slot 1 fires and `seq_busy` goes high.
- R3: The gap between slot k and slot k+1 (k = 1..9) is selected by bit k-1 of register address 0: 0 gives 2 ms, 1 gives 5 ms. One millisecond is CLK_PER_MS cycles, so slot k+1 fires exactly gap cycles after slot k.
- R4: A rail whose 4-bit slot field (register address 1+i, bits 3:0) holds s in 1..10 is enabled at the edge where slot s fires. Rails that share a slot rise at the same edge.
- R5: A rail whose slot field is 0 or 11..15 is never enabled.
- R6: While `pwr_en` stays high, an enable that is set never falls.
- R7: At an edge that samples `pwr_en` low, all enables, `seq_busy` and `seq_done` clear. This holds even when a slot would fire at that same edge.
- R8: `seq_busy` stays high until slot 10 fires. At that edge `seq_busy` falls and `seq_done` rises. The two are never high together.
- R9: Register writes are ignored while the sequence runs and on the edge that starts it. Writes to addresses above NUM_RAILS have no effect.
- R10: If `pwr_en` stays high after `seq_done`, nothing restarts and the enables hold. A new run needs `pwr_en` to go low and then high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_en | input | 1 | Power-enable request; a rise starts, low clears |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Register address (0 = gap selects, 1+i = slot of rail i) |
| cfg_wdata | input | DATA_W | Register write data |
| rail_en | output | NUM_RAILS | Rail enable outputs |
| seq_busy | output | 1 | Sequence running |
| seq_done | output | 1 | Slot 10 has fired |

## Verification
Two pairs of events can land on the same clock edge, and the bench forces both.

The first pair is a drop of the request and a strobe firing. The bench lowers `pwr_en` in the cycle just before a computed strobe edge. It then expects every output to be zero after that edge, not the newly enabled rails.

The second pair is a configuration write and a sequence start. The bench raises `pwr_en` and writes a new gap register in the same cycle. It expects the timing to follow the old configuration, both in that run and in a later restart.

// File: rtl/rseq_pkg.sv
package rseq_pkg;
    localparam int NUM_SLOTS = 10;
    localparam int NUM_GAPS  = NUM_SLOTS - 1;
    localparam int SLOT_W    = 4;
    localparam int SHORT_MS  = 2;
    localparam int LONG_MS   = 5;

    typedef logic [SLOT_W-1:0]   slot_t;
    typedef logic [NUM_GAPS-1:0] gap_sel_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } seq_state_e;

    function automatic logic slot_valid(slot_t s);
        return (s >= slot_t'(1)) && (s <= slot_t'(NUM_SLOTS));
    endfunction

    function automatic slot_t default_slot(int idx);
        return slot_t'((idx % NUM_SLOTS) + 1);
    endfunction
endpackage

// File: rtl/rseq_regs.sv
module rseq_regs
    import rseq_pkg::*;
#(
    parameter int NUM_RAILS = 8,
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic                         lock,
    output logic [NUM_RAILS-1:0][SLOT_W-1:0] rail_slot,
    output gap_sel_t                     gap_sel
);
    logic accept;
    assign accept = wr_en && !lock;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_sel <= '0;
        end else if (accept && (wr_addr == '0)) begin
            gap_sel <= wr_data[NUM_GAPS-1:0];
        end
    end

    for (genvar gi = 0; gi < NUM_RAILS; gi++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                rail_slot[gi] <= default_slot(gi);
            end else if (accept && (wr_addr == ADDR_W'(gi + 1))) begin
                rail_slot[gi] <= wr_data[SLOT_W-1:0];
            end
        end
    end

    // R9: configuration frozen while locked
    assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (rst)
        lock |=> ($stable(rail_slot) && $stable(gap_sel)));
endmodule

// File: rtl/rseq_timer.sv
module rseq_timer
    import rseq_pkg::*;
#(
    parameter int CLK_PER_MS = 250000
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic long_sel,
    output logic expire
);
    localparam int PRE_W = (CLK_PER_MS > 1) ? $clog2(CLK_PER_MS) : 1;
    localparam int MS_W  = 3;

    logic [PRE_W-1:0] pre_q;
    logic [MS_W-1:0]  ms_q;
    logic             pre_wrap;
    logic [MS_W-1:0]  ms_last;

    assign pre_wrap = (pre_q == PRE_W'(CLK_PER_MS - 1));
    assign ms_last  = long_sel ? MS_W'(LONG_MS - 1) : MS_W'(SHORT_MS - 1);
    assign expire   = pre_wrap && (ms_q == ms_last);

    always_ff @(posedge clk) begin
        if (rst || clear || expire) begin
            pre_q <= '0;
            ms_q  <= '0;
        end else if (pre_wrap) begin
            pre_q <= '0;
            ms_q  <= ms_q + MS_W'(1);
        end else begin
            pre_q <= pre_q + PRE_W'(1);
        end
    end

    // R3: prescaler and millisecond count stay in range
    assert_pre_range_R3: assert property (@(posedge clk) disable iff (rst)
        (pre_q <= PRE_W'(CLK_PER_MS - 1)) && (ms_q <= MS_W'(LONG_MS - 1)));
endmodule

// File: rtl/rseq_ctrl.sv
module rseq_ctrl
    import rseq_pkg::*;
#(
    parameter int NUM_RAILS = 8
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             pwr_en,
    input  logic                             expire,
    input  logic [NUM_RAILS-1:0][SLOT_W-1:0] rail_slot,
    input  gap_sel_t                         gap_sel,
    output logic [NUM_RAILS-1:0]             rail_en,
    output logic                             busy,
    output logic                             done,
    output logic                             timer_clear,
    output logic                             long_sel,
    output logic                             lock
);
    seq_state_e           state_q;
    slot_t                slot_q;
    logic                 pwr_q;
    logic                 start;
    logic                 fire;
    slot_t                next_slot;
    logic [NUM_RAILS-1:0] hit;

    assign start     = pwr_en && !pwr_q && (state_q == ST_IDLE);
    assign fire      = (state_q == ST_RUN) && expire;
    assign next_slot = start ? slot_t'(1) : (slot_q + slot_t'(1));

    for (genvar gi = 0; gi < NUM_RAILS; gi++) begin : g_hit
        assign hit[gi] = (rail_slot[gi] == next_slot);
    end

    always_comb begin
        long_sel = 1'b0;
        for (int k = 1; k <= NUM_GAPS; k++) begin
            if (slot_q == slot_t'(k)) long_sel = gap_sel[k-1];
        end
    end

    assign timer_clear = (state_q != ST_RUN) || expire;
    assign lock        = (state_q == ST_RUN) || start;
    assign busy        = (state_q == ST_RUN);
    assign done        = (state_q == ST_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            slot_q  <= '0;
            rail_en <= '0;
            pwr_q   <= 1'b0;
        end else begin
            pwr_q <= pwr_en;
            if (!pwr_en) begin
                state_q <= ST_IDLE;
                slot_q  <= '0;
                rail_en <= '0;
            end else if (start) begin
                state_q <= ST_RUN;
                slot_q  <= slot_t'(1);
                rail_en <= hit;
            end else if (fire) begin
                slot_q  <= next_slot;
                rail_en <= rail_en | hit;
                if (next_slot == slot_t'(NUM_SLOTS)) state_q <= ST_DONE;
            end
        end
    end

    // R3: a running sequence always points at a slot with a following gap
    assert_slot_range_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN) |-> (slot_valid(slot_q) && (slot_q != slot_t'(NUM_SLOTS))));
    // R6: enables never fall while the request holds
    assert_en_hold_R6: assert property (@(posedge clk) disable iff (rst)
        pwr_en |=> ((rail_en & $past(rail_en)) == $past(rail_en)));
    // R8: done only rises out of a running sequence
    assert_done_after_busy_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(busy));
    // R5: a rail with an invalid slot field is never enabled by a firing
    assert_invalid_slot_R5: assert property (@(posedge clk) disable iff (rst)
        ((start || fire) && pwr_en) |=> ((rail_en & ~$past(rail_en) & ~$past(hit)) == '0));
endmodule

// File: rtl/rail_sequencer.sv
module rail_sequencer
    import rseq_pkg::*;
#(
    parameter int NUM_RAILS  = 8,
    parameter int ADDR_W     = 4,
    parameter int DATA_W     = 16,
    parameter int CLK_PER_MS = 250000
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 pwr_en,
    input  logic                 cfg_wr,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic [DATA_W-1:0]    cfg_wdata,
    output logic [NUM_RAILS-1:0] rail_en,
    output logic                 seq_busy,
    output logic                 seq_done
);
    logic [NUM_RAILS-1:0][SLOT_W-1:0] rail_slot;
    gap_sel_t                         gap_sel;
    logic                             lock;
    logic                             expire;
    logic                             timer_clear;
    logic                             long_sel;

    rseq_regs #(
        .NUM_RAILS (NUM_RAILS),
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (cfg_wr),
        .wr_addr   (cfg_addr),
        .wr_data   (cfg_wdata),
        .lock      (lock),
        .rail_slot (rail_slot),
        .gap_sel   (gap_sel)
    );

    rseq_timer #(
        .CLK_PER_MS (CLK_PER_MS)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .clear    (timer_clear),
        .long_sel (long_sel),
        .expire   (expire)
    );

    rseq_ctrl #(
        .NUM_RAILS (NUM_RAILS)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .pwr_en      (pwr_en),
        .expire      (expire),
        .rail_slot   (rail_slot),
        .gap_sel     (gap_sel),
        .rail_en     (rail_en),
        .busy        (seq_busy),
        .done        (seq_done),
        .timer_clear (timer_clear),
        .long_sel    (long_sel),
        .lock        (lock)
    );

    // R7: a low request clears every output at the next edge
    assert_drop_clears_R7: assert property (@(posedge clk) disable iff (rst)
        !pwr_en |=> ((rail_en == '0) && !seq_busy && !seq_done));
    // R8: busy and done are exclusive
    assert_busy_done_excl_R8: assert property (@(posedge clk) disable iff (rst)
        !(seq_busy && seq_done));
endmodule

// File: tb/rail_sequencer_bench.sv
module rail_sequencer_bench;
    localparam int NR  = 8;
    localparam int AW  = 4;
    localparam int DW  = 16;
    localparam int CPM = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pwr_en = 1'b0;
    logic          cfg_wr = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [DW-1:0] cfg_wdata = '0;
    logic [NR-1:0] rail_en;
    logic          seq_busy;
    logic          seq_done;

    int checks = 0;
    int fails  = 0;

    logic [NR-1:0][3:0] m_slot;
    logic [8:0]         m_gap;
    int                 t_fire [1:10];

    always #2 clk = ~clk;

    rail_sequencer #(
        .NUM_RAILS (NR), .ADDR_W (AW), .DATA_W (DW), .CLK_PER_MS (CPM)
    ) u_rail_sequencer (
        .clk (clk), .rst (rst), .pwr_en (pwr_en), .cfg_wr (cfg_wr),
        .cfg_addr (cfg_addr), .cfg_wdata (cfg_wdata),
        .rail_en (rail_en), .seq_busy (seq_busy), .seq_done (seq_done)
    );

    task automatic check(input string tag, input logic [NR+1:0] got, input logic [NR+1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got en/busy/done=%b expected %b", tag, got, exp);
        end
    endtask

    task automatic compute_times();
        t_fire[1] = 0;
        for (int k = 1; k < 10; k++)
            t_fire[k+1] = t_fire[k] + (m_gap[k-1] ? 5 : 2) * CPM;
    endtask

    function automatic logic [NR+1:0] expect_at(input int m);
        logic [NR-1:0] e;
        e = '0;
        for (int i = 0; i < NR; i++) begin
            int s;
            s = int'(m_slot[i]);
            if (s >= 1 && s <= 10 && t_fire[s] <= m) e[i] = 1'b1;
        end
        return {e, (m < t_fire[10]), (m >= t_fire[10])};
    endfunction

    task automatic write_reg(input int a, input int d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = AW'(a); cfg_wdata = DW'(d);
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic drop_and_check(input string tag);
        @(negedge clk);
        pwr_en = 1'b0;
        @(negedge clk);
        check(tag, {rail_en, seq_busy, seq_done}, '0);
    endtask

    // stop_at >= 0: pwr_en drops in the cycle before that many cycles after start
    task automatic run_seq(input string tag, input bit wr_at_start, input bit wr_mid, input int stop_at);
        compute_times();
        @(negedge clk);
        pwr_en = 1'b1;
        if (wr_at_start) begin
            cfg_wr = 1'b1; cfg_addr = '0; cfg_wdata = 16'h01FF;
        end
        @(posedge clk);
        for (int m = 0; m <= t_fire[10] + 2; m++) begin
            @(negedge clk);
            cfg_wr = 1'b0;
            if (stop_at >= 0 && m == stop_at - 1) begin
                pwr_en = 1'b0;
                @(negedge clk);
                check({tag, " R7 drop on strobe edge"}, {rail_en, seq_busy, seq_done}, '0);
                return;
            end
            check(tag, {rail_en, seq_busy, seq_done}, expect_at(m));
            if (wr_mid && m == 3) begin
                cfg_wr = 1'b1; cfg_addr = AW'(2); cfg_wdata = 16'd10;
            end
        end
    endtask

    initial begin
        for (int i = 0; i < NR; i++) m_slot[i] = 4'((i % 10) + 1);
        m_gap = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset outputs", {rail_en, seq_busy, seq_done}, '0);

        // R1 R2 R3 R4 R8: default order
        run_seq("R2 R4 R8 default", 1'b0, 1'b0, -1);
        drop_and_check("R7 drop after default");

        // R3 R4 R5: mixed gaps, shared, zero and out-of-range slots
        m_gap = 9'b1_0101_0101;
        m_slot[0] = 4'd10; m_slot[1] = 4'd1; m_slot[2] = 4'd1; m_slot[3] = 4'd0;
        m_slot[4] = 4'd12; m_slot[5] = 4'd5; m_slot[6] = 4'd9; m_slot[7] = 4'd2;
        write_reg(0, int'(m_gap));
        for (int i = 0; i < NR; i++) write_reg(i + 1, int'(m_slot[i]));
        write_reg(12, 4'd1); // R9: address beyond rails, no effect
        run_seq("R3 R4 R5 custom", 1'b0, 1'b0, -1);
        // R10: held request after done, no restart
        for (int m = 0; m < 12; m++) begin
            @(negedge clk);
            check("R10 hold after done", {rail_en, seq_busy, seq_done}, expect_at(1000));
        end
        drop_and_check("R7 drop after custom");

        // R9: writes at start and mid-run ignored, checked in this run and the next
        run_seq("R9 writes while running", 1'b1, 1'b1, -1);
        drop_and_check("R7 drop after R9 run");
        run_seq("R9 config unchanged", 1'b0, 1'b0, -1);
        drop_and_check("R7 drop after R9 rerun");

        // R7: drop coincides with strobe 4 and strobe 10
        compute_times();
        run_seq("R7 coincide s4", 1'b0, 1'b0, t_fire[4]);
        @(negedge clk);
        run_seq("R7 coincide s10", 1'b0, 1'b0, t_fire[10]);

        // R3: all gaps long
        m_gap = 9'h1FF;
        write_reg(0, int'(m_gap));
        run_seq("R3 all long", 1'b0, 1'b0, -1);
        drop_and_check("R7 final drop");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule